// File: doc/BRIEF.md
# TDM Serial Audio Frame Receiver

This block is a slave receiver for an eight-slot time-division-multiplexed audio stream. It runs on the incoming bit clock and takes two serial inputs: a frame-sync pulse and one data line. Every frame is 256 bit clocks long and holds eight 32-bit slots. Each slot carries a left-justified 24-bit two's-complement sample, and the remaining bits of the slot are zero padding. The receiver finds the start of each frame from the sync pulse, shifts each slot in MSB first, and keeps the top 24 bits of each slot.

When a frame is complete, all eight samples are presented together on one packed output bus, and a one-cycle valid strobe marks the update. If a sync pulse arrives after any number of bit clocks other than 256, the receiver raises a sticky framing error and realigns to the new pulse. The parent uses the error flag to mute or restart the audio path. The flag clears only on reset.

Top module: `tdm_frame_rx`

## Requirements
- R1: During and after reset, `frame_valid_o` and `frame_err_o` are 0 and `samples_o` is all zeros.
- R2: Data bits sampled before the first sync pulse after reset are ignored, so no valid strobe occurs. The first sync pulse never raises the framing error.
- R3: The bit sampled on the rising edge right after the sync edge is the MSB of slot 0. Slot n occupies the 32 rising edges that start 32·n edges after that MSB. Its first 24 bits, MSB first, appear as a two's-complement value on `samples_o[24n+23:24n]`.
- R4: The last 8 bits of each slot have no effect on `samples_o`, whatever their values.
- R5: `frame_valid_o` is high for exactly one cycle, in the cycle that follows the edge sampling bit 255 of a frame. `samples_o` changes only in that cycle and holds its value otherwise.
- R6: A sync pulse sampled at a frame position other than bit 255 sets `frame_err_o`. The cut-short frame produces no valid strobe. The next frame is aligned to the new pulse and decodes correctly.
- R7: A frame whose bit 255 carries no sync pulse still produces its valid strobe. No further strobe occurs until the next sync pulse, and that late pulse sets `frame_err_o`.
- R8: Once set, `frame_err_o` stays high through later well-formed frames until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Serial bit clock; all inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame-sync pulse, one bit clock wide, sampled on the edge before slot 0 MSB |
| sdata_i | input | 1 | Serial data, MSB first |
| samples_o | output | 192 | Eight 24-bit samples, slot n at bits 24n+23:24n |
| frame_valid_o | output | 1 | One-cycle strobe when `samples_o` is updated |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
The bench targets the edge where the sync pulse and the last bit of the previous frame share one clock. A design that resets its position counter before using that bit would lose slot 7 or place the strobe one cycle off. Padding bits set to ones catch a receiver that keeps the wrong 24 bits of a slot, and full-scale positive and negative samples catch a bit-order or sign slip. An early sync and a missing sync are each tested after a clean reset. These tests catch a design that strobes out a truncated frame, fails to realign, counts the missing sync as harmless, or lets later good frames clear the error.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int DEF_SLOTS    = 8;
  localparam int DEF_SLOT_W   = 32;
  localparam int DEF_SAMPLE_W = 24;

  typedef struct packed {
    logic bit_en;     // a frame bit is being sampled this edge
    logic frame_end;  // this edge samples the last bit of the frame
  } rx_evt_t;
endpackage

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  output logic [POS_W-1:0] pos_o,
  output rx_evt_t          evt_o,
  output logic             err_o
);
  localparam int CNT_W = POS_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] pos_q;
  logic             locked_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (fsync_i) begin
      if (locked_q && pos_q != LAST) err_q <= 1'b1;
      pos_q    <= '0;
      locked_q <= 1'b1;
    end else if (locked_q && pos_q != '1) begin
      pos_q <= pos_q + 1'b1;  // saturates when sync goes missing
    end
  end

  assign pos_o           = pos_q[POS_W-1:0];
  assign evt_o.bit_en    = locked_q && (pos_q < CNT_W'(FRAME_BITS));
  assign evt_o.frame_end = locked_q && (pos_q == LAST);
  assign err_o           = err_q;

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r6_err_only_on_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(fsync_i));
  a_r6_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_i |=> (pos_q == '0 && locked_q));
endmodule

// File: rtl/tdm_rx_slotter.sv
module tdm_rx_slotter #(
  parameter int SLOTS    = 8,
  parameter int SLOT_W   = 32,
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = $clog2(SLOTS * SLOT_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sdata_i,
  input  logic                      bit_en_i,
  input  logic [POS_W-1:0]          pos_i,
  output logic [SLOTS*SAMPLE_W-1:0] stage_o
);
  localparam int SLOT_LSB = $clog2(SLOT_W);
  localparam int IDX_W    = POS_W - SLOT_LSB;

  logic [SAMPLE_W-2:0]  sh_q;
  logic [SAMPLE_W-1:0]  word;
  logic [IDX_W-1:0]     idx;
  logic [SLOT_LSB-1:0]  off;
  logic                 take;

  assign word = {sh_q, sdata_i};
  assign idx  = pos_i[POS_W-1:SLOT_LSB];
  assign off  = pos_i[SLOT_LSB-1:0];
  assign take = bit_en_i && (off == SLOT_LSB'(SAMPLE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (bit_en_i) sh_q <= word[SAMPLE_W-2:0];
  end

  // one staging register per slot; padding bits after the sample are never taken
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SAMPLE_W-1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           stage_q <= '0;
      else if (take && idx == IDX_W'(g))     stage_q <= word;
    end
    assign stage_o[g*SAMPLE_W +: SAMPLE_W] = stage_q;
  end
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS    = DEF_SLOTS,
  parameter int SLOT_W   = DEF_SLOT_W,
  parameter int SAMPLE_W = DEF_SAMPLE_W  // must be below SLOT_W
) (
  input  logic                      sclk_i,
  input  logic                      rst_ni,
  input  logic                      fsync_i,
  input  logic                      sdata_i,
  output logic [SLOTS*SAMPLE_W-1:0] samples_o,
  output logic                      frame_valid_o,
  output logic                      frame_err_o
);
  localparam int FRAME_BITS = SLOTS * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);

  logic [POS_W-1:0]          pos;
  rx_evt_t                   evt;
  logic [SLOTS*SAMPLE_W-1:0] stage;
  logic [SLOTS*SAMPLE_W-1:0] samples_q;
  logic                      valid_q;

  tdm_rx_framer #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_framer (
    .clk_i   (sclk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .pos_o   (pos),
    .evt_o   (evt),
    .err_o   (frame_err_o)
  );

  tdm_rx_slotter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_slotter (
    .clk_i    (sclk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (sdata_i),
    .bit_en_i (evt.bit_en),
    .pos_i    (pos),
    .stage_o  (stage)
  );

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samples_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= evt.frame_end;
      if (evt.frame_end) samples_q <= stage;
    end
  end

  assign samples_o     = samples_q;
  assign frame_valid_o = valid_q;

  a_r5_valid_pulse: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  a_r5_hold_between: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !$stable(samples_q) |-> valid_q);
endmodule

// File: tb/sim_tdm_frame_rx.sv
module sim_tdm_frame_rx;
  localparam int PER = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fs = 1'b0;
  logic         sd = 1'b0;
  logic [191:0] smp_o;
  logic         vld_o;
  logic         err_o;

  int total = 0;
  int bad   = 0;
  logic [23:0] cur  [8];
  logic [23:0] prev [8];

  always #(PER/2) clk = ~clk;

  tdm_frame_rx u0 (
    .sclk_i(clk), .rst_ni(rst_n), .fsync_i(fs), .sdata_i(sd),
    .samples_o(smp_o), .frame_valid_o(vld_o), .frame_err_o(err_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic f, logic d);
    @(negedge clk);
    fs = f; sd = d;
    @(posedge clk);
    #(PER/4);
  endtask

  function automatic logic [23:0] gen(int f, int ch);
    if (f == 1) return ch[0] ? 24'h7FFFFF : 24'h800000;
    if (f == 2) return ch[0] ? 24'h000000 : 24'hFFFFFF;
    return 24'((f * 40503 + ch * 191251 + 17) * (ch + 3));
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; fs = 1'b0; sd = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(vld_o), 0);
    check("R1 err in reset", 32'(err_o), 0);
    check("R1 samples in reset", 32'(|smp_o), 0);
    rst_n = 1'b1;
    for (int ch = 0; ch < 8; ch++) prev[ch] = '0;
  endtask

  // frame alignment must already be set by a prior sync edge
  task automatic send_frame(int f, logic pad, logic end_sync, logic exp_err);
    int badv = 0;
    for (int ch = 0; ch < 8; ch++) cur[ch] = gen(f, ch);
    for (int b = 0; b < 256; b++) begin
      int sl = b / 32;
      int k  = b % 32;
      put(end_sync && b == 255, (k < 24) ? cur[sl][23-k] : pad);
      if (b == 0) check("R5 strobe one cycle", 32'(vld_o), 0);
      if (b < 255 && vld_o) badv++;
      if (b == 128)
        for (int ch = 0; ch < 8; ch++)
          check("R5 samples held mid-frame", 32'(smp_o[ch*24 +: 24]), 32'(prev[ch]));
    end
    check("R5 no early strobe", 32'(badv), 0);
    check("R5 strobe after bit 255", 32'(vld_o), 1);
    for (int ch = 0; ch < 8; ch++)
      check(pad ? "R4 padding ignored" : "R3 slot sample",
            32'(smp_o[ch*24 +: 24]), 32'(cur[ch]));
    check("R8 err state", 32'(err_o), 32'(exp_err));
    for (int ch = 0; ch < 8; ch++) prev[ch] = cur[ch];
  endtask

  initial begin
    #(PER * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nv;
    do_reset();
    // R2: stream before any sync
    nv = 0;
    for (int b = 0; b < 300; b++) begin
      put(1'b0, logic'(b[0] ^ b[3]));
      if (vld_o) nv++;
    end
    check("R2 no strobe before sync", 32'(nv), 0);
    put(1'b1, 1'b1);
    check("R2 first sync no error", 32'(err_o), 0);

    // R3/R4/R5: back-to-back frames
    send_frame(1, 1'b0, 1'b1, 1'b0);
    send_frame(2, 1'b1, 1'b1, 1'b0);
    send_frame(3, 1'b0, 1'b1, 1'b0);
    send_frame(4, 1'b1, 1'b1, 1'b0);

    // R6: sync arrives after 100 bits
    nv = 0;
    for (int b = 0; b < 100; b++) begin
      put(b == 99, logic'(b[1]));
      if (vld_o) nv++;
    end
    check("R6 err on early sync", 32'(err_o), 1);
    check("R6 no strobe for cut frame", 32'(nv), 0);
    send_frame(5, 1'b0, 1'b1, 1'b1);   // R6 realigned decode
    send_frame(6, 1'b1, 1'b1, 1'b1);   // R8 still set

    // R7: missing sync, after a fresh reset (R8 cleared only by reset)
    do_reset();
    put(1'b1, 1'b0);
    check("R8 err cleared by reset", 32'(err_o), 0);
    send_frame(7, 1'b0, 1'b0, 1'b0);
    nv = 0;
    for (int b = 0; b < 300; b++) begin
      put(1'b0, logic'(b[2]));
      if (vld_o) nv++;
    end
    check("R7 no strobe without sync", 32'(nv), 0);
    check("R7 no err before late sync", 32'(err_o), 0);
    put(1'b1, 1'b0);
    check("R7 late sync sets err", 32'(err_o), 1);
    send_frame(8, 1'b1, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule